// File: doc/BRIEF.md
# Prioritized Two-Stream Packet Merger

This block collects packets from two independent producers: a bursty stream of pin-trace events and a steady, rate-bounded stream of power samples. It funnels them into one slow external memory that is used as a ring buffer. Each stream lands first in its own on-chip FIFO, which takes one 32-bit packet on every clock. This lets short bursts arrive far faster than the memory can absorb them. An arbiter then moves one packet at a time from the FIFOs to the memory port. One memory access takes many cycles and is closed by an acknowledge.

When both FIFOs hold data at a decision point, the power stream always wins. Its rate is low and bounded, so it cannot starve the trace stream for long, and it is never held back behind a trace burst. Only one memory write is in flight at a time. The next choice is made only after the current write has been acknowledged. A downstream serial drain reads the ring through a read address and a pop strobe. When the ring is full, the arbiter stops and the backlog stays in the FIFOs. A packet that reaches a full FIFO is discarded and counted.

Top module: `dual_stream_merger`

## Requirements
- R1: While a FIFO is not full, it accepts a packet on every cycle its valid input is high. Its fill output rises by one per accepted packet when nothing is popped.
- R2: A packet offered to a full FIFO is discarded. That stream's overflow flag is then set and stays set until reset. That stream's lost counter rises by one per discarded packet and saturates at its maximum.
- R3: Power packets (bit 31 of the packet is the bench's stream tag) are chosen over trace packets whenever both FIFOs are non-empty at a decision. With four packets queued on each stream at once, the memory receives the four power packets first and then the four trace packets.
- R4: At most one memory write is outstanding. `mem_req` stays high with stable `mem_addr` and `mem_wdata` until `mem_ack`. It is low in the cycle after the acknowledge.
- R5: Successive writes go to consecutive ring addresses, starting at 0 after reset and wrapping modulo 2^RING_AW.
- R6: When `ring_level` equals 2^RING_AW, `ring_full` is high and no new write is started. `ring_level` never exceeds 2^RING_AW.
- R7: `drain_pop` with `drain_avail` high advances `drain_addr` by one (wrapping) and lowers the level by one. `drain_pop` while the ring is empty changes neither.
- R8: Each accepted packet is written exactly once. Packets of the same stream keep their arrival order.
- R9: After reset, both FIFOs and the ring are empty, no request is pending, and the flags and counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pw_valid | input | 1 | Power packet present this cycle |
| pw_data | input | DW | Power packet |
| tr_valid | input | 1 | Trace packet present this cycle |
| tr_data | input | DW | Trace packet |
| mem_req | output | 1 | Write request to the external memory |
| mem_addr | output | RING_AW | Ring address of the write |
| mem_wdata | output | DW | Packet being written |
| mem_ack | input | 1 | One-cycle completion of the current write |
| drain_avail | output | 1 | Ring holds at least one packet |
| drain_addr | output | RING_AW | Ring address of the oldest packet |
| drain_pop | input | 1 | Drain has consumed the packet at `drain_addr` |
| ring_level | output | RING_AW+1 | Packets held in the ring |
| ring_full | output | 1 | Ring holds 2^RING_AW packets |
| pw_fill | output | $clog2(FIFO_DEPTH)+1 | Power FIFO occupancy |
| tr_fill | output | $clog2(FIFO_DEPTH)+1 | Trace FIFO occupancy |
| pw_ovf | output | 1 | Sticky power-FIFO overflow |
| tr_ovf | output | 1 | Sticky trace-FIFO overflow |
| pw_lost | output | LOST_W | Discarded power packets |
| tr_lost | output | LOST_W | Discarded trace packets |

## Verification
A wrong arbitration choice shows at the memory port on the very next write: a trace packet appears while power packets are still queued. A corrupted write pointer shows as a non-consecutive `mem_addr` on the next request. A corrupted level shows as a stall with free space, or as a write into a full ring. FIFO pointer faults surface later, at the drain, as a stream sequence number that is skipped, repeated or out of order. Miscounted occupancy shows at once in `pw_fill`/`tr_fill` and in the loss counters after a burst into a blocked FIFO.

// File: rtl/merger_pkg.sv
package merger_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_LOAD = 2'd1,
    ARB_WAIT = 2'd2
  } arb_state_t;

  typedef enum logic {
    SRC_TRACE = 1'b0,
    SRC_POWER = 1'b1
  } src_t;
endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter int DW     = 32,
  parameter int DEPTH  = 1024,
  parameter int LOST_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          nempty,
  output logic [AW:0]   fill,
  output logic          ovf,
  output logic [LOST_W-1:0] lost
);
  localparam logic [AW:0] CNT_MAX = (AW+1)'(DEPTH);

  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          is_full, push_ok, pop_ok;

  assign is_full = (cnt == CNT_MAX);
  assign push_ok = push && !is_full;
  assign pop_ok  = pop && (cnt != '0);

  // storage: no reset, so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) store[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) dout <= store[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
      lost <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push && is_full) begin
        ovf <= 1'b1;
        if (lost != '1) lost <= lost + 1'b1;
      end
    end
  end

  assign nempty = (cnt != '0);
  assign fill   = cnt;
endmodule

// File: rtl/ring_ptrs.sv
module ring_ptrs #(
  parameter int RAW = 18
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           commit,
  input  logic           drain_pop,
  output logic [RAW-1:0] wr_addr,
  output logic [RAW-1:0] rd_addr,
  output logic [RAW:0]   level,
  output logic           full,
  output logic           avail
);
  localparam logic [RAW:0] LVL_MAX = (RAW+1)'(1) << RAW;

  logic pop_ok;
  assign pop_ok = drain_pop && (level != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr <= '0;
      rd_addr <= '0;
      level   <= '0;
    end else begin
      if (commit) wr_addr <= wr_addr + 1'b1;
      if (pop_ok) rd_addr <= rd_addr + 1'b1;
      case ({commit, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign full  = (level == LVL_MAX);
  assign avail = (level != '0);
endmodule

// File: rtl/wr_arbiter.sv
module wr_arbiter
  import merger_pkg::*;
#(
  parameter int DW  = 32,
  parameter int RAW = 18
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pw_nempty,
  input  logic           tr_nempty,
  input  logic [DW-1:0]  pw_dout,
  input  logic [DW-1:0]  tr_dout,
  input  logic           ring_full,
  input  logic [RAW-1:0] wr_addr,
  input  logic           mem_ack,
  output logic           pw_pop,
  output logic           tr_pop,
  output logic           commit,
  output logic           mem_req,
  output logic [RAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata
);
  arb_state_t state;
  src_t       src;
  logic       take;

  always_comb begin
    take   = (state == ARB_IDLE) && !ring_full && (pw_nempty || tr_nempty);
    pw_pop = take && pw_nempty;
    tr_pop = take && !pw_nempty && tr_nempty;
    commit = (state == ARB_WAIT) && mem_ack;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ARB_IDLE;
      src       <= SRC_TRACE;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (state)
        ARB_IDLE: if (take) begin
          src   <= pw_nempty ? SRC_POWER : SRC_TRACE;
          state <= ARB_LOAD;
        end
        ARB_LOAD: begin
          mem_req   <= 1'b1;
          mem_addr  <= wr_addr;
          mem_wdata <= (src == SRC_POWER) ? pw_dout : tr_dout;
          state     <= ARB_WAIT;
        end
        ARB_WAIT: if (mem_ack) begin
          mem_req <= 1'b0;
          state   <= ARB_IDLE;
        end
        default: state <= ARB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_stream_merger.sv
module dual_stream_merger #(
  parameter int DW         = 32,
  parameter int FIFO_DEPTH = 1024,
  parameter int RING_AW    = 18,
  parameter int LOST_W     = 16,
  localparam int FAW       = $clog2(FIFO_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pw_valid,
  input  logic [DW-1:0]      pw_data,
  input  logic               tr_valid,
  input  logic [DW-1:0]      tr_data,
  output logic               mem_req,
  output logic [RING_AW-1:0] mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic               mem_ack,
  output logic               drain_avail,
  output logic [RING_AW-1:0] drain_addr,
  input  logic               drain_pop,
  output logic [RING_AW:0]   ring_level,
  output logic               ring_full,
  output logic [FAW:0]       pw_fill,
  output logic [FAW:0]       tr_fill,
  output logic               pw_ovf,
  output logic               tr_ovf,
  output logic [LOST_W-1:0]  pw_lost,
  output logic [LOST_W-1:0]  tr_lost
);
  logic [DW-1:0]      pw_dout, tr_dout;
  logic               pw_nempty, tr_nempty, pw_pop, tr_pop, commit;
  logic [RING_AW-1:0] wr_addr;

  pkt_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH), .LOST_W(LOST_W)) u_pw_fifo (
    .clk(clk), .rst(rst), .push(pw_valid), .din(pw_data), .pop(pw_pop),
    .dout(pw_dout), .nempty(pw_nempty), .fill(pw_fill), .ovf(pw_ovf),
    .lost(pw_lost)
  );

  pkt_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH), .LOST_W(LOST_W)) u_tr_fifo (
    .clk(clk), .rst(rst), .push(tr_valid), .din(tr_data), .pop(tr_pop),
    .dout(tr_dout), .nempty(tr_nempty), .fill(tr_fill), .ovf(tr_ovf),
    .lost(tr_lost)
  );

  wr_arbiter #(.DW(DW), .RAW(RING_AW)) u_arb (
    .clk(clk), .rst(rst), .pw_nempty(pw_nempty), .tr_nempty(tr_nempty),
    .pw_dout(pw_dout), .tr_dout(tr_dout), .ring_full(ring_full),
    .wr_addr(wr_addr), .mem_ack(mem_ack), .pw_pop(pw_pop), .tr_pop(tr_pop),
    .commit(commit), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  ring_ptrs #(.RAW(RING_AW)) u_ring (
    .clk(clk), .rst(rst), .commit(commit), .drain_pop(drain_pop),
    .wr_addr(wr_addr), .rd_addr(drain_addr), .level(ring_level),
    .full(ring_full), .avail(drain_avail)
  );
endmodule

// File: rtl/merger_checker.sv
module merger_checker #(
  parameter int DW         = 32,
  parameter int FIFO_DEPTH = 1024,
  parameter int RING_AW    = 18,
  localparam int FAW       = $clog2(FIFO_DEPTH)
) (
  input logic               clk,
  input logic               rst,
  input logic               pw_valid,
  input logic               tr_valid,
  input logic [FAW:0]       pw_fill,
  input logic [FAW:0]       tr_fill,
  input logic               pw_ovf,
  input logic               tr_ovf,
  input logic               mem_req,
  input logic               mem_ack,
  input logic [RING_AW-1:0] mem_addr,
  input logic [DW-1:0]      mem_wdata,
  input logic [RING_AW:0]   ring_level,
  input logic               ring_full,
  input logic               drain_pop,
  input logic               drain_avail,
  input logic [RING_AW-1:0] drain_addr
);
  localparam logic [FAW:0]     F_MAX = (FAW+1)'(FIFO_DEPTH);
  localparam logic [RING_AW:0] L_MAX = (RING_AW+1)'(1) << RING_AW;

  a_r2_tr_drop_flags: assert property (@(posedge clk) disable iff (rst)
    tr_valid && (tr_fill == F_MAX) |=> tr_ovf);
  a_r2_pw_drop_flags: assert property (@(posedge clk) disable iff (rst)
    pw_valid && (pw_fill == F_MAX) |=> pw_ovf);
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    (tr_ovf || pw_ovf) |=> ($past(tr_ovf) -> tr_ovf) && ($past(pw_ovf) -> pw_ovf));
  a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));
  a_r4_ack_ends_req: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> !mem_req);
  a_r6_no_start_full: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> !ring_full);
  a_r6_level_bound: assert property (@(posedge clk) disable iff (rst)
    ring_level <= L_MAX);
  a_r7_empty_pop: assert property (@(posedge clk) disable iff (rst)
    drain_pop && !drain_avail |=> $stable(drain_addr));
endmodule

bind dual_stream_merger merger_checker #(
  .DW(DW), .FIFO_DEPTH(FIFO_DEPTH), .RING_AW(RING_AW)
) u_chk (
  .clk(clk), .rst(rst), .pw_valid(pw_valid), .tr_valid(tr_valid),
  .pw_fill(pw_fill), .tr_fill(tr_fill), .pw_ovf(pw_ovf), .tr_ovf(tr_ovf),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .ring_level(ring_level), .ring_full(ring_full),
  .drain_pop(drain_pop), .drain_avail(drain_avail), .drain_addr(drain_addr)
);

// File: tb/dual_stream_merger_tb.sv
module dual_stream_merger_tb;
  localparam int DW = 32, FD = 16, RAW = 5, LW = 8, LAT = 16;
  localparam int FAW = $clog2(FD);
  localparam int RDEP = 1 << RAW;

  logic clk = 1'b0, rst = 1'b1;
  logic pw_valid = 0, tr_valid = 0;
  logic [DW-1:0] pw_data = '0, tr_data = '0;
  logic mem_req, mem_ack = 0, drain_avail, drain_pop = 0, ring_full;
  logic [RAW-1:0] mem_addr, drain_addr;
  logic [DW-1:0] mem_wdata;
  logic [RAW:0] ring_level;
  logic [FAW:0] pw_fill, tr_fill;
  logic pw_ovf, tr_ovf;
  logic [LW-1:0] pw_lost, tr_lost;

  always #2.5 clk = ~clk;

  dual_stream_merger #(.DW(DW), .FIFO_DEPTH(FD), .RING_AW(RAW), .LOST_W(LW)) u_dut (
    .clk(clk), .rst(rst), .pw_valid(pw_valid), .pw_data(pw_data),
    .tr_valid(tr_valid), .tr_data(tr_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .drain_avail(drain_avail), .drain_addr(drain_addr), .drain_pop(drain_pop),
    .ring_level(ring_level), .ring_full(ring_full), .pw_fill(pw_fill),
    .tr_fill(tr_fill), .pw_ovf(pw_ovf), .tr_ovf(tr_ovf), .pw_lost(pw_lost),
    .tr_lost(tr_lost)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0, drain_en = 0, force_pop = 0;
  logic [DW-1:0] mem_model [RDEP];
  logic [DW-1:0] obs [4096];
  int n_obs = 0, lat_cnt = 0, exp_waddr = 0, addr_err = 0, req_while_full = 0;

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pkt(input bit pw, input int seq);
    return {pw, 31'(seq)};
  endfunction

  // external memory model: fixed latency, one-cycle acknowledge
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 0; lat_cnt = 0; exp_waddr = 0;
    end else if (mem_ack) begin
      mem_ack = 0;
    end else if (mem_req) begin
      if (ring_full) req_while_full++;
      lat_cnt++;
      if (lat_cnt == LAT) begin
        if (int'(mem_addr) != exp_waddr % RDEP) addr_err++;
        exp_waddr++;
        mem_model[mem_addr] = mem_wdata;
        mem_ack = 1; lat_cnt = 0;
      end
    end
  end

  // downstream drain model
  always @(negedge clk) begin
    if (rst) begin
      n_obs = 0; drain_pop = 0;
    end else begin
      drain_pop = (drain_en && drain_avail) || force_pop;
      if (drain_en && drain_avail) begin
        obs[n_obs] = mem_model[drain_addr];
        n_obs++;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1; pw_valid = 0; tr_valid = 0; drain_en = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R9 level", ring_level == 0, ring_level, 0);
    check("R9 req", mem_req == 0 && drain_avail == 0, mem_req, 0);
    check("R9 fills", pw_fill == 0 && tr_fill == 0, pw_fill + tr_fill, 0);
    check("R9 flags", {pw_ovf, tr_ovf} == 0 && pw_lost == 0 && tr_lost == 0,
          pw_lost + tr_lost, 0);
  endtask

  task automatic wait_obs(input int n);
    for (int k = 0; k < 20000 && n_obs < n; k++) @(negedge clk);
  endtask

  initial begin
    // ---- R3: both streams queued together, power first ----
    do_reset();
    drain_en = 1;
    for (int i = 0; i < 4; i++) begin
      pw_valid = 1; pw_data = pkt(1, i);
      tr_valid = 1; tr_data = pkt(0, i);
      @(negedge clk);
    end
    pw_valid = 0; tr_valid = 0;
    wait_obs(8);
    check("R8 count", n_obs == 8, n_obs, 8);
    for (int i = 0; i < 8; i++) begin
      logic [DW-1:0] e;
      e = (i < 4) ? pkt(1, i) : pkt(0, i - 4);
      check("R3 order", obs[i] == e, obs[i], e);
    end
    check("R5 addr", addr_err == 0, addr_err, 0);

    // ---- R6/R2/R1: fill ring, then burst into blocked trace FIFO ----
    do_reset();
    for (int i = 0; i < RDEP; i++) begin
      pw_valid = 1; pw_data = pkt(1, i);
      @(negedge clk); pw_valid = 0;
      repeat (20) @(negedge clk);
    end
    for (int k = 0; k < 200 && !ring_full; k++) @(negedge clk);
    check("R6 full", ring_full == 1 && int'(ring_level) == RDEP, ring_level, RDEP);
    req_while_full = 0;
    for (int i = 0; i < 20; i++) begin
      tr_valid = 1; tr_data = pkt(0, i);
      @(negedge clk);
      if (i == 4) check("R1 fill", tr_fill == 5, tr_fill, 5);
    end
    tr_valid = 0;
    repeat (40) @(negedge clk);
    check("R6 stall", req_while_full == 0 && mem_req == 0, req_while_full, 0);
    check("R1 full fill", tr_fill == FD, tr_fill, FD);
    check("R2 lost", tr_lost == 4, tr_lost, 4);
    check("R2 ovf", tr_ovf == 1 && pw_ovf == 0 && pw_lost == 0, tr_ovf, 1);
    drain_en = 1;
    wait_obs(RDEP + FD);
    check("R8 count", n_obs == RDEP + FD, n_obs, RDEP + FD);
    for (int i = 0; i < RDEP + FD; i++) begin
      logic [DW-1:0] e;
      e = (i < RDEP) ? pkt(1, i) : pkt(0, i - RDEP);
      if (obs[i] != e) check("R8 seq", 0, obs[i], e);
    end
    check("R5 wrap addr", addr_err == 0, addr_err, 0);
    check("R2 sticky", tr_ovf == 1, tr_ovf, 1);
    // R7: pop on empty ring
    repeat (5) @(negedge clk);
    begin
      logic [RAW-1:0] a0;
      a0 = drain_addr;
      drain_en = 0; force_pop = 1;
      repeat (3) @(negedge clk);
      force_pop = 0;
      @(negedge clk);
      check("R7 empty pop addr", drain_addr == a0, drain_addr, a0);
      check("R7 empty pop level", ring_level == 0, ring_level, 0);
      check("R7 drain addr", int'(a0) == (RDEP + FD) % RDEP, a0, (RDEP + FD) % RDEP);
    end

    // ---- random mixed traffic, R8 ----
    do_reset();
    drain_en = 1;
    begin
      int seed_dummy, np, nt, gp, gt, bad;
      seed_dummy = $urandom(32'h5eed_1234);
      np = 0; nt = 0;
      for (int c = 0; c < 6000; c++) begin
        pw_valid = ($urandom % 80) == 0;
        tr_valid = ($urandom % 60) == 0;
        pw_data = pkt(1, np); tr_data = pkt(0, nt);
        if (pw_valid) np++;
        if (tr_valid) nt++;
        @(negedge clk);
      end
      pw_valid = 0; tr_valid = 0;
      wait_obs(np + nt);
      check("R8 total", n_obs == np + nt, n_obs, np + nt);
      gp = 0; gt = 0; bad = 0;
      for (int i = 0; i < n_obs; i++) begin
        if (obs[i][31]) begin
          if (obs[i] != pkt(1, gp)) bad++;
          gp++;
        end else begin
          if (obs[i] != pkt(0, gt)) bad++;
          gt++;
        end
      end
      check("R8 order", bad == 0, bad, 0);
      check("R2 no loss", pw_lost == 0 && tr_lost == 0, pw_lost + tr_lost, 0);
      check("R5 addr", addr_err == 0, addr_err, 0);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule